// File: doc/BRIEF.md
# Slave Device State Controller

This block holds the communication state of a fieldbus slave node and decides which of the node's services may run. The bus master asks for a new state by presenting a state code with a one-cycle valid strobe. The controller takes the request only if it is a permitted step. Upward steps also need a ready signal from the local application. A refused request leaves the state as it was and raises a sticky error flag, which only a master acknowledge clears. A watchdog timeout while fully operational drops the node back to the state in which outputs are held safe, and it also raises the error flag.

The state code is decoded into four enable lines: one for mailbox channels, one for process-data channels, one that lets the physical outputs follow process data, and one for the firmware download path. In the safe-operational state, process data moves but the outputs stay at their safe values. The bootstrap state is a separate branch used only for firmware download.

Top module: `node_state_ctrl`

## Requirements
- R1: After reset, st_code is 1 (Init), fault is 0 and all four enable lines are 0.
- R2: The state codes are Init=1, PreOp=2, Boot=3, SafeOp=4 and Op=8, and st_code only ever shows one of these. In Init all enables are 0. In PreOp only mbx_en is 1. In Boot only fw_en is 1.
- R3: In SafeOp, mbx_en and pd_en are 1 and drv_en is 0. In Op, mbx_en, pd_en and drv_en are all 1. drv_en is never 1 unless pd_en and mbx_en are both 1.
- R4: The upward steps Init→PreOp, PreOp→SafeOp, SafeOp→Op and Init→Boot are taken when app_rdy is 1 during the request cycle. st_code shows the new code from the next cycle on.
- R5: An upward step requested while app_rdy is 0 leaves the state unchanged and sets fault.
- R6: Any other request sets fault and leaves the state unchanged. This covers skipping a state, leaving Boot for anything but Init, entering Boot from anything but Init, and codes outside the five.
- R7: A step down to a lower state of the chain Init<PreOp<SafeOp<Op, and Boot→Init, is taken whatever app_rdy is.
- R8: fault stays at 1 until a cycle with fault_ack at 1. If a new fault arises in that same cycle, fault stays at 1.
- R9: wdt_expire in Op moves the state to SafeOp and sets fault, and this takes priority over a request in the same cycle. In any other state wdt_expire has no effect.
- R10: A request for the current state changes nothing and raises no fault.
- R11: Without req_vld or wdt_expire the state does not change, whatever req_code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Master state request strobe |
| req_code | input | 4 | Requested state code |
| app_rdy | input | 1 | Local application ready for an upward step |
| fault_ack | input | 1 | Master acknowledge, clears fault |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| st_code | output | 4 | Current state code |
| fault | output | 1 | Sticky error flag |
| mbx_en | output | 1 | Mailbox channels enabled |
| pd_en | output | 1 | Process-data channels active |
| drv_en | output | 1 | Outputs follow process data (0 = held safe) |
| fw_en | output | 1 | Firmware download path enabled |

## Verification
On every cycle, the in-module assertions check that the state code is valid and that the enables are consistent with one another. They also check that Boot can be entered only from Init and Op only from SafeOp, that fault is sticky, that the state holds when no request or timeout arrives, and that a timeout in Op lands in SafeOp with fault set. Whether a given request is accepted or refused depends on the request code and on app_rdy. Only the bench's request sequences show this, together with the ordering of an acknowledge and a new fault in the same cycle and the timeout taking priority over a request.

// File: rtl/node_state_ctrl.sv
module node_state_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [CW-1:0] req_code,
  input  logic          app_rdy,
  input  logic          fault_ack,
  input  logic          wdt_expire,
  output logic [CW-1:0] st_code,
  output logic          fault,
  output logic          mbx_en,
  output logic          pd_en,
  output logic          drv_en,
  output logic          fw_en
);

  localparam logic [CW-1:0] S_INIT = CW'(1);
  localparam logic [CW-1:0] S_PRE  = CW'(2);
  localparam logic [CW-1:0] S_BOOT = CW'(3);
  localparam logic [CW-1:0] S_SAFE = CW'(4);
  localparam logic [CW-1:0] S_OP   = CW'(8);

  logic [CW-1:0] st_q, st_d;
  logic          flt_q, flt_set;
  logic          step_up, step_dn;

  assign step_up = (st_q == S_INIT && (req_code == S_PRE || req_code == S_BOOT))
                 || (st_q == S_PRE  && req_code == S_SAFE)
                 || (st_q == S_SAFE && req_code == S_OP);

  assign step_dn = (st_q == S_PRE  && req_code == S_INIT)
                 || (st_q == S_BOOT && req_code == S_INIT)
                 || (st_q == S_SAFE && (req_code == S_INIT || req_code == S_PRE))
                 || (st_q == S_OP   && (req_code == S_INIT || req_code == S_PRE
                                        || req_code == S_SAFE));

  always_comb begin
    st_d    = st_q;
    flt_set = 1'b0;
    if (wdt_expire && st_q == S_OP) begin
      st_d    = S_SAFE;
      flt_set = 1'b1;
    end else if (req_vld && req_code != st_q) begin
      if (step_dn)
        st_d = req_code;
      else if (step_up && app_rdy)
        st_d = req_code;
      else
        flt_set = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_INIT;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      flt_q <= flt_set | (flt_q & ~fault_ack);
    end
  end

  assign st_code = st_q;
  assign fault   = flt_q;
  assign mbx_en  = (st_q == S_PRE) || (st_q == S_SAFE) || (st_q == S_OP);
  assign pd_en   = (st_q == S_SAFE) || (st_q == S_OP);
  assign drv_en  = (st_q == S_OP);
  assign fw_en   = (st_q == S_BOOT);

  assert_valid_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_code == S_INIT || st_code == S_PRE || st_code == S_BOOT
    || st_code == S_SAFE || st_code == S_OP);

  assert_boot_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fw_en |-> !(mbx_en || pd_en || drv_en));

  assert_drv_needs_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (pd_en && mbx_en));

  assert_boot_from_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code != S_INIT && st_code != S_BOOT) |=> (st_code != S_BOOT));

  assert_op_from_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code != S_SAFE && st_code != S_OP) |=> (st_code != S_OP));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_ack) |=> fault);

  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !req_vld && !wdt_expire) |=> !fault);

  assert_wdt_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire && st_code == S_OP) |=> (st_code == S_SAFE && fault));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld && !wdt_expire) |=> $stable(st_code));

endmodule

// File: tb/node_state_ctrl_test.sv
`timescale 1ns/1ps
module node_state_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_vld = 1'b0, app_rdy = 1'b0, fault_ack = 1'b0, wdt_expire = 1'b0;
  logic [3:0] req_code = 4'd0;
  logic [3:0] st_code;
  logic       fault, mbx_en, pd_en, drv_en, fw_en;
  int         total = 0, bad = 0;

  always #2.5 clk = ~clk;

  node_state_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_code(req_code),
    .app_rdy(app_rdy), .fault_ack(fault_ack), .wdt_expire(wdt_expire),
    .st_code(st_code), .fault(fault), .mbx_en(mbx_en), .pd_en(pd_en),
    .drv_en(drv_en), .fw_en(fw_en)
  );

  // vector: {req_code, app_rdy, fault_ack, exp_state, exp_fault}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 4'd2, 1'b0},  // R4 Init->PreOp
    {4'd4, 1'b0, 1'b0, 4'd2, 1'b1},  // R5 not ready
    {4'd2, 1'b0, 1'b1, 4'd2, 1'b0},  // R10 same state, R8 ack clears
    {4'd4, 1'b1, 1'b0, 4'd4, 1'b0},  // R4 PreOp->SafeOp
    {4'd8, 1'b1, 1'b0, 4'd8, 1'b0},  // R4 SafeOp->Op
    {4'd3, 1'b1, 1'b0, 4'd8, 1'b1},  // R6 Op->Boot refused
    {4'd1, 1'b0, 1'b0, 4'd1, 1'b1},  // R7 Op->Init without ready
    {4'd8, 1'b1, 1'b1, 4'd1, 1'b1},  // R8 new fault wins over ack
    {4'd1, 1'b1, 1'b1, 4'd1, 1'b0},  // R10 same state, ack clears
    {4'd3, 1'b1, 1'b0, 4'd3, 1'b0},  // R4 Init->Boot
    {4'd2, 1'b1, 1'b0, 4'd3, 1'b1},  // R6 Boot->PreOp refused
    {4'd1, 1'b0, 1'b1, 4'd1, 1'b0},  // R7 Boot->Init without ready
    {4'd5, 1'b1, 1'b0, 4'd1, 1'b1},  // R6 unknown code
    {4'd2, 1'b1, 1'b1, 4'd2, 1'b0},  // R4 Init->PreOp with ack
    {4'd4, 1'b1, 1'b0, 4'd4, 1'b0},  // R4
    {4'd2, 1'b0, 1'b0, 4'd2, 1'b0},  // R7 SafeOp->PreOp
    {4'd8, 1'b1, 1'b0, 4'd2, 1'b1},  // R6 skip refused
    {4'd1, 1'b0, 1'b1, 4'd1, 1'b0}   // R7 PreOp->Init
  };

  function automatic logic [3:0] exp_en(input logic [3:0] s);
    case (s)
      4'd2:    return 4'b1000;
      4'd3:    return 4'b0001;
      4'd4:    return 4'b1100;
      4'd8:    return 4'b1110;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] c, input logic r,
                       input logic a, input logic w);
    @(negedge clk);
    req_vld = v; req_code = c; app_rdy = r; fault_ack = a; wdt_expire = w;
    @(negedge clk);
    req_vld = 1'b0; fault_ack = 1'b0; wdt_expire = 1'b0; app_rdy = 1'b0;
  endtask

  task automatic chk_state(input string tag, input logic [3:0] s, input logic f);
    chk(tag, {3'b0, fault, st_code}, {3'b0, f, s});
    chk({tag, " enables"}, {4'b0, mbx_en, pd_en, drv_en, fw_en}, {4'b0, exp_en(s)});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 reset", 4'd1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i][10:7], VEC[i][6], VEC[i][5], 1'b0);
      chk_state($sformatf("R2 R3 vector %0d", i), VEC[i][4:1], VEC[i][0]);
    end

    // R11: request code without strobe is ignored
    apply(1'b0, 4'd2, 1'b1, 1'b0, 1'b0);
    chk_state("R11 no strobe", 4'd1, 1'b0);

    // R9: timeout outside Op ignored
    apply(1'b1, 4'd2, 1'b1, 1'b0, 1'b0);
    apply(1'b0, 4'd0, 1'b0, 1'b0, 1'b1);
    chk_state("R9 timeout in PreOp ignored", 4'd2, 1'b0);

    // R9: timeout in Op wins over a request in the same cycle
    apply(1'b1, 4'd4, 1'b1, 1'b0, 1'b0);
    apply(1'b1, 4'd8, 1'b1, 1'b0, 1'b0);
    chk_state("R3 in Op", 4'd8, 1'b0);
    apply(1'b1, 4'd1, 1'b1, 1'b0, 1'b1);
    chk_state("R9 timeout in Op", 4'd4, 1'b1);

    // R8: fault holds with no ack, then ack alone clears it
    apply(1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    chk_state("R8 fault held", 4'd4, 1'b1);
    apply(1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
    chk_state("R8 ack clears", 4'd4, 1'b0);

    // R1: reset from a non-initial state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_state("R1 re-reset", 4'd1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule